// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets clocked logic use an external asynchronous static RAM of 512K sixteen-bit words. The client side is a single-request handshake: the client raises a request with a direction flag, a word address, write data and a byte mask, and the controller answers with a one-cycle done pulse (carrying the read word for reads). The RAM side carries a registered address bus, a pair of chip enables of opposite polarity, write and output enables, per-byte lane selects, and a data bus split into drive value, drive enable and sampled input.

Every RAM phase lasts a whole number of clocks, derived at elaboration from the clock period and the selected speed grade, so the RAM's minimum access, pulse, setup and float times are always covered. Writes are framed by a setup clock and a hold clock with write enable high, so the address only ever moves while write enable is high and write data outlives the terminating edge. After every read a turnaround interval lets the RAM's output drivers float before the bus can be driven again.

Top module: `sram_timing_ctrl`

## Requirements
- R1: After reset the controller is idle: req_ready is 1, ram_ce1_n 1, ram_ce2 0, ram_we_n 1, ram_oe_n 1, both ram_lane_n bits 1, ram_dq_oe 0 and rsp_done 0.
- R2: The two chip enables always move together: ram_ce1_n is 0 exactly when ram_ce2 is 1, held for the whole of each access.
- R3: A read holds the address with ram_oe_n low, ram_we_n high and both lanes selected for RD_CYC = ceil(55 ns, or 70 ns in the slow grade, / period) clocks; the word on ram_dq_in is registered on the edge that ends that phase, and rsp_done appears RD_CYC clocks after the accepting edge.
- R4: ram_addr changes only in a clock where ram_we_n is high both before and after the change.
- R5: A write drives data for one setup clock with ram_we_n high, then holds ram_we_n low for WP_CYC = ceil(max(35, 45, 25) ns, or max(35, 60, 30) ns, / period) clocks, then one hold clock with ram_we_n high while data and chip enables remain; rsp_done appears WP_CYC+2 clocks after the accepting edge.
- R6: On writes, req_mask bit 0 selects lane 0 (data bits 7:0) and bit 1 selects lane 1 (bits 15:8); a lane select is driven low only for a set mask bit, and bytes of cleared mask bits keep their old value in the RAM.
- R7: ram_dq_oe is 1 only during write phases and never while ram_oe_n is low.
- R8: After each read the chip enables and output enable are released and the bus stays undriven for at least HZ_CYC = ceil(25 ns, or 30 ns, / period) clocks before the next access begins.
- R9: A request is taken only on an edge where req_ready is 1; a request raised and dropped while the controller is busy is ignored.
- R10: rsp_done is high for exactly one clock per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Client request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Byte mask for writes, bit i enables lane i |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_rdata | output | 16 | Read word, valid with rsp_done of a read |
| rsp_done | output | 1 | One-clock completion pulse |
| ram_addr | output | 19 | RAM address bus |
| ram_ce1_n | output | 1 | RAM chip enable, active low |
| ram_ce2 | output | 1 | RAM chip enable, active high |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_lane_n | output | 2 | RAM byte lane selects, active low, bit 0 = low byte |
| ram_dq_out | output | 16 | Value driven onto the RAM data bus |
| ram_dq_oe | output | 1 | Drive enable for the RAM data bus |
| ram_dq_in | input | 16 | Value sampled from the RAM data bus |

## Verification
The hardest situation to reach is a read whose data is captured one clock early or a write issued while the RAM is still driving after a read, because a zero-delay memory would hide both. The bench's RAM model therefore returns a poison word until the read strobes have been steady for the required number of clocks, keeps driving for the float time after release, and flags any overlap with the controller's drive. Random back-to-back read/write mixes over a small address pool with random masks (including an empty mask) create read-then-write turnarounds and partial-lane overwrites, and a directed request pulsed during a busy read checks that it is dropped.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACCESS,
        PH_RD_FLOAT,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_HOLD
    } phase_e;

    // Whole clocks covering a duration, never less than one.
    function automatic int clocks_for(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
    parameter int LANES = 2
) (
    input  logic             all_lanes,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] lane_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_n[i] = ~(all_lanes | mask[i]);
    end
endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl #(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int SLOW_GRADE  = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                req_ready,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_done,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic                ram_ce1_n,
    output logic                ram_ce2,
    output logic                ram_we_n,
    output logic                ram_oe_n,
    output logic [DATA_W/8-1:0] ram_lane_n,
    output logic [DATA_W-1:0]   ram_dq_out,
    output logic                ram_dq_oe,
    input  logic [DATA_W-1:0]   ram_dq_in
);
    import sram_ctrl_pkg::*;

    localparam int LANES    = DATA_W / 8;
    // RAM minimum times per grade, in ns
    localparam int ACCESS_NS = (SLOW_GRADE != 0) ? 70 : 55;
    localparam int ADDR_END_NS = (SLOW_GRADE != 0) ? 60 : 45;
    localparam int DSETUP_NS = (SLOW_GRADE != 0) ? 30 : 25;
    localparam int WPULSE_NS = 35;
    localparam int FLOAT_NS  = (SLOW_GRADE != 0) ? 30 : 25;

    localparam int RD_CYC = clocks_for(ACCESS_NS, CLK_PERIOD_NS);
    localparam int WP_CYC = clocks_for(max_of3(WPULSE_NS, ADDR_END_NS, DSETUP_NS), CLK_PERIOD_NS);
    localparam int HZ_CYC = clocks_for(FLOAT_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC = max_of3(RD_CYC, WP_CYC, HZ_CYC);
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic              ce1_n;
        logic              ce2;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  lane_n;
        logic [DATA_W-1:0] dq_out;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } ctrl_s;

    localparam ctrl_s CTRL_RST = '{
        phase:  PH_IDLE,
        addr:   '0,
        ce1_n:  1'b1,
        ce2:    1'b0,
        we_n:   1'b1,
        oe_n:   1'b1,
        lane_n: '1,
        dq_out: '0,
        dq_oe:  1'b0,
        rdata:  '0,
        done:   1'b0
    };

    ctrl_s            ctrl_q, ctrl_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [LANES-1:0] req_lane_n;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_lane_sel #(.LANES(LANES)) u_lanes (
        .all_lanes (~req_write),
        .mask      (req_mask),
        .lane_n    (req_lane_n)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        unique case (ctrl_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    ctrl_d.addr   = req_addr;
                    ctrl_d.ce1_n  = 1'b0;
                    ctrl_d.ce2    = 1'b1;
                    ctrl_d.lane_n = req_lane_n;
                    if (req_write) begin
                        ctrl_d.phase  = PH_WR_SETUP;
                        ctrl_d.dq_out = req_wdata;
                        ctrl_d.dq_oe  = 1'b1;
                    end else begin
                        ctrl_d.phase = PH_RD_ACCESS;
                        ctrl_d.oe_n  = 1'b0;
                        tmr_load     = 1'b1;
                        tmr_val      = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_RD_ACCESS: begin
                if (tmr_expired) begin
                    ctrl_d.rdata  = ram_dq_in;
                    ctrl_d.done   = 1'b1;
                    ctrl_d.ce1_n  = 1'b1;
                    ctrl_d.ce2    = 1'b0;
                    ctrl_d.oe_n   = 1'b1;
                    ctrl_d.lane_n = '1;
                    ctrl_d.phase  = PH_RD_FLOAT;
                    tmr_load      = 1'b1;
                    tmr_val       = CNT_W'(HZ_CYC - 1);
                end
            end
            PH_RD_FLOAT: begin
                if (tmr_expired) begin
                    ctrl_d.phase = PH_IDLE;
                end
            end
            PH_WR_SETUP: begin
                ctrl_d.we_n  = 1'b0;
                ctrl_d.phase = PH_WR_PULSE;
                tmr_load     = 1'b1;
                tmr_val      = CNT_W'(WP_CYC - 1);
            end
            PH_WR_PULSE: begin
                if (tmr_expired) begin
                    ctrl_d.we_n  = 1'b1;
                    ctrl_d.phase = PH_WR_HOLD;
                end
            end
            PH_WR_HOLD: begin
                ctrl_d.ce1_n  = 1'b1;
                ctrl_d.ce2    = 1'b0;
                ctrl_d.lane_n = '1;
                ctrl_d.dq_oe  = 1'b0;
                ctrl_d.done   = 1'b1;
                ctrl_d.phase  = PH_IDLE;
            end
            default: begin
                ctrl_d = CTRL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready  = (ctrl_q.phase == PH_IDLE);
    assign rsp_rdata  = ctrl_q.rdata;
    assign rsp_done   = ctrl_q.done;
    assign ram_addr   = ctrl_q.addr;
    assign ram_ce1_n  = ctrl_q.ce1_n;
    assign ram_ce2    = ctrl_q.ce2;
    assign ram_we_n   = ctrl_q.we_n;
    assign ram_oe_n   = ctrl_q.oe_n;
    assign ram_lane_n = ctrl_q.lane_n;
    assign ram_dq_out = ctrl_q.dq_out;
    assign ram_dq_oe  = ctrl_q.dq_oe;
endmodule

// File: rtl/sram_timing_ctrl_chk.sv
module sram_timing_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                rsp_done,
    input logic [ADDR_W-1:0]   ram_addr,
    input logic                ram_ce1_n,
    input logic                ram_ce2,
    input logic                ram_we_n,
    input logic                ram_oe_n,
    input logic [DATA_W/8-1:0] ram_lane_n,
    input logic [DATA_W-1:0]   ram_dq_out,
    input logic                ram_dq_oe
);
    a_r2_enables_paired: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce1_n == !ram_ce2);

    a_r3_read_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (ram_lane_n == '0 && ram_we_n && !ram_ce1_n));

    a_r4_addr_moves_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_addr != $past(ram_addr)) |-> (ram_we_n && $past(ram_we_n)));

    a_r5_we_low_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce1_n && ram_dq_oe && ram_oe_n));

    a_r5_data_held_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (ram_dq_oe && !ram_ce1_n && $stable(ram_dq_out)));

    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);

    a_r9_ready_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_ce1_n && ram_we_n && ram_oe_n && !ram_dq_oe));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind sram_timing_ctrl sram_timing_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .ram_addr   (ram_addr),
    .ram_ce1_n  (ram_ce1_n),
    .ram_ce2    (ram_ce2),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_lane_n (ram_lane_n),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe)
);

// File: tb/test_sram_timing_ctrl.sv
module test_sram_timing_ctrl;
    localparam int T_NS = 10;

    function automatic int ceil_clk(input int ns);
        return (ns + T_NS - 1) / T_NS;
    endfunction

    localparam int RD_EXP = (55 + T_NS - 1) / T_NS;
    localparam int WP_EXP = (45 + T_NS - 1) / T_NS;
    localparam int HZ_EXP = (25 + T_NS - 1) / T_NS;
    localparam logic [15:0] POISON = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic        rsp_done;
    logic [18:0] ram_addr;
    logic        ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n;
    logic [1:0]  ram_lane_n;
    logic [15:0] ram_dq_out;
    logic        ram_dq_oe;
    logic [15:0] ram_dq_in;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sram_timing_ctrl i_sram_timing_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_lane_n(ram_lane_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    // ---------------- RAM model ----------------
    logic [15:0] ram_mem [int];
    logic [15:0] ref_mem [int];

    function automatic logic [15:0] fill_word(input logic [18:0] a);
        return a[15:0] ^ 16'hA55A ^ {a[18:16], 13'b0};
    endfunction

    function automatic logic [15:0] ref_word(input logic [18:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill_word(a);
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] m);
        return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
    endfunction

    logic        sel, rd_act;
    int          rd_cnt = 0, float_tail = 0, we_cnt = 0, addr_age = 0, data_age = 0;
    int          viol_r2 = 0, viol_r4 = 0, viol_r7 = 0, viol_r5 = 0;
    int          last_pulse = 0, last_addr_age = 0, last_data_age = 0, done_cnt = 0;
    logic [18:0] prev_addr = '0;
    logic        prev_we_n = 1'b1, prev_oe = 1'b0;
    logic [15:0] prev_dq = '0;

    assign sel    = !ram_ce1_n && ram_ce2;
    assign rd_act = sel && !ram_oe_n && ram_we_n;

    always_comb begin
        logic [15:0] w;
        w = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : fill_word(ram_addr);
        if (rd_act && rd_cnt >= RD_EXP)
            ram_dq_in = {ram_lane_n[1] ? POISON[15:8] : w[15:8],
                         ram_lane_n[0] ? POISON[7:0]  : w[7:0]};
        else
            ram_dq_in = POISON;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_done) done_cnt++;
            if (ram_ce1_n != !ram_ce2) viol_r2++;
            if (ram_dq_oe && (rd_act || float_tail > 0)) viol_r7++;
            if (rd_act) float_tail = HZ_EXP;
            else if (float_tail > 0) float_tail--;
            if (rd_act) rd_cnt = (ram_addr == prev_addr || rd_cnt == 0) ? rd_cnt + 1 : 1;
            else rd_cnt = 0;
            if (ram_addr != prev_addr) begin
                addr_age = 1;
                if (!ram_we_n || !prev_we_n) viol_r4++;
            end else addr_age++;
            if (ram_dq_oe) data_age = (prev_oe && ram_dq_out == prev_dq) ? data_age + 1 : 1;
            else data_age = 0;
            if (!ram_we_n) we_cnt++;
            if (!prev_we_n && ram_we_n) begin
                if (sel && ram_dq_oe) begin
                    logic [15:0] w;
                    w = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)]
                                                       : fill_word(ram_addr);
                    ram_mem[int'(ram_addr)] = merge(w, ram_dq_out, ~ram_lane_n);
                end else viol_r5++;
                last_pulse = we_cnt;
                last_addr_age = addr_age;
                last_data_age = data_age;
                we_cnt = 0;
            end
        end
        prev_addr = ram_addr;
        prev_we_n = ram_we_n;
        prev_oe   = ram_dq_oe;
        prev_dq   = ram_dq_out;
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    int v2, v4, v7, v5;
    task automatic snap_viol();
        v2 = viol_r2; v4 = viol_r4; v7 = viol_r7; v5 = viol_r5;
    endtask

    task automatic check_viol();
        check(viol_r2 == v2, "R2", "enable pairing violations", viol_r2 - v2, 0);
        check(viol_r4 == v4, "R4", "address moved with WE low", viol_r4 - v4, 0);
        check(viol_r7 == v7, "R8", "bus fight with RAM output", viol_r7 - v7, 0);
        check(viol_r5 == v5, "R5", "write end without data/select", viol_r5 - v5, 0);
    endtask

    task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] m);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!rsp_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] m);
        int lat;
        snap_viol();
        issue(1'b1, a, d, m);
        wait_done(lat);
        check(lat == WP_EXP + 2, "R5", "write done latency", lat, WP_EXP + 2);
        check(last_pulse >= ceil_clk(35), "R5", "WE low clocks", last_pulse, ceil_clk(35));
        check(last_addr_age >= ceil_clk(45) + 1, "R5", "address to write end",
              last_addr_age, ceil_clk(45) + 1);
        check(last_data_age >= ceil_clk(25) + 1, "R5", "data setup+hold",
              last_data_age, ceil_clk(25) + 1);
        ref_mem[int'(a)] = merge(ref_word(a), d, m);
        @(negedge clk);
        check(!rsp_done, "R10", "done length", rsp_done, 0);
        check_viol();
    endtask

    task automatic do_read(input logic [18:0] a);
        int lat;
        snap_viol();
        issue(1'b0, a, '0, 2'b00);
        wait_done(lat);
        check(lat == RD_EXP, "R3", "read done latency", lat, RD_EXP);
        check(rsp_rdata == ref_word(a), "R6", "read word", rsp_rdata, ref_word(a));
        @(negedge clk);
        check(!rsp_done, "R10", "done length", rsp_done, 0);
        check_viol();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    logic [18:0] pool [8];

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check({ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n} == 4'b1011, "R1", "strobes in reset",
              {ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n}, 4'b1011);
        check(ram_lane_n == 2'b11 && !ram_dq_oe && !rsp_done, "R1", "lanes/drive/done",
              {ram_lane_n, ram_dq_oe, rsp_done}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && ram_ce1_n == 1'b1, "R1", "idle after reset",
              {req_ready, ram_ce1_n}, 2'b11);

        // directed corners
        do_write(19'h00000, 16'h1234, 2'b11);
        do_read(19'h00000);
        do_write(19'h7FFFF, 16'hBEEF, 2'b11);
        do_read(19'h7FFFF);
        do_write(19'h00000, 16'hAB00, 2'b10);   // R6 upper lane only
        do_read(19'h00000);
        do_write(19'h00000, 16'h00CD, 2'b01);   // R6 lower lane only
        do_read(19'h00000);
        do_write(19'h00000, 16'hFFFF, 2'b00);   // R6 no lane: unchanged
        do_read(19'h00000);
        do_read(19'h12345);                      // R3 never-written word
        do_write(19'h12345, 16'h5A5A, 2'b11);   // R8 write right after read

        // R9: request pulsed during a busy read is ignored
        begin
            int d0, lat;
            d0 = done_cnt;
            snap_viol();
            issue(1'b0, 19'h00100, '0, 2'b00);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00100;
            req_wdata = 16'h0BAD; req_mask = 2'b11;
            @(negedge clk);
            req_valid = 1'b0;
            wait_done(lat);
            check(rsp_rdata == ref_word(19'h00100), "R9", "read during intrusion",
                  rsp_rdata, ref_word(19'h00100));
            repeat (20) @(negedge clk);
            check(done_cnt - d0 == 1, "R9", "completions for one request", done_cnt - d0, 1);
            check_viol();
            do_read(19'h00100);
        end

        // constrained random mix
        pool[0] = 19'h00000; pool[1] = 19'h7FFFF;
        for (int i = 2; i < 8; i++) pool[i] = 19'($urandom);
        for (int i = 0; i < 300; i++) begin
            logic [18:0] a;
            a = pool[$urandom % 8];
            if ($urandom % 2 == 0) do_read(a);
            else do_write(a, 16'($urandom), 2'($urandom));
        end
        for (int i = 0; i < 8; i++) do_read(pool[i]);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule